// File: doc/BRIEF.md
# Cache Line Flit Packetizer

The packetizer turns one memory-system message at a time into a packet of flits for an on-chip network link. A message is either a full 64-byte cache line or a short coherence command with no data. Alongside the message the source supplies a route field, a message type, a virtual channel number and an address. Each flit is exactly one link transfer wide, so the link never needs to split a flit into smaller pieces.

A cache line leaves as four flits. The first flit carries the routing and identification fields together with the first 16 bytes of the line. Two middle flits and a closing flit carry the remaining bytes in ascending order. A command leaves as a single flit that both opens and closes the packet. Every flit names the virtual channel, so a downstream buffer can steer the middle and closing flits without keeping per-packet state. Each packet also gets a wrapping sequence number in its opening flit.

Both edges use a valid/ready handshake. The block takes a new message only when it is idle, and it holds a stalled flit steady until the link accepts it.

Top module: `flit_packetizer`

## Requirements
- R1: Bits [FLIT_W-1:FLIT_W-2] of every flit hold a type code: 0 = head, 1 = body, 2 = tail, 3 = combined head-and-tail.
- R2: A data message (msg_is_data_i = 1) produces exactly four flits in the order head, body, body, tail. Their payloads, in the low 128 bits, are line bytes 0-15, 16-31, 32-47 and 48-63, with byte 0 in bits [7:0] of the head payload.
- R3: Below the type code, a head flit carries, from high to low: VC (2 bits), route (6 bits), message type (3 bits), sequence number (6 bits), address (34 bits), then the payload.
- R4: Body and tail flits carry the packet's VC in the same field as the head flit. The route, message type, sequence and address fields of these flits are zero.
- R5: A command message (msg_is_data_i = 0) produces one flit of type 3. It carries the route, message type, sequence number, VC and address fields as in R3, and its payload holds the 8-bit command, zero-extended.
- R6: msg_ready_o is high exactly when no packet is in progress. A message is taken on a cycle where msg_valid_i and msg_ready_o are both high. After the last flit of a packet is handed off, the block is idle again on the next cycle.
- R7: While flit_valid_o is high and flit_ready_i is low, the flit stays unchanged and the block does not move to the next flit.
- R8: The sequence number is 0 for the first packet after reset and goes up by one for each accepted message, wrapping modulo 64.
- R9: During and right after reset, flit_valid_o is low and msg_ready_o is high.
- R10: From the cycle after a message is accepted until its last flit is handed off, flit_valid_o stays high. With flit_ready_i held high, a cache line therefore takes four consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message offered |
| msg_ready_o | output | 1 | Block is idle and can take a message |
| msg_is_data_i | input | 1 | 1 = cache line message, 0 = command |
| msg_route_i | input | 6 | Destination route information |
| msg_type_i | input | 3 | Message type |
| msg_vc_i | input | 2 | Virtual channel identifier |
| msg_addr_i | input | 34 | Address |
| msg_cmd_i | input | 8 | Coherence command (command messages) |
| msg_line_i | input | 512 | Cache line, byte 0 in bits [7:0] |
| flit_valid_o | output | 1 | Flit available |
| flit_ready_i | input | 1 | Link accepts the flit |
| flit_o | output | 181 | Flit: type, VC, header fields, 128-bit payload |

## Verification
The hardest case to reach is a stall on each individual flit position of a cache-line packet, including the closing flit, combined with a new message waiting at the input the whole time. Only this combination shows whether the flit index and the idle return stay correct. The stimulus keeps a message pending almost constantly and drives link ready at random with several probabilities, from always-ready down to rare acceptance, so long stalls land on every position. Mixed command and data traffic over more than 64 packets takes the sequence number through its wrap.

// File: rtl/flit_pkg.sv
package flit_pkg;
  typedef enum logic [1:0] {
    FT_HEAD   = 2'd0,
    FT_BODY   = 2'd1,
    FT_TAIL   = 2'd2,
    FT_SINGLE = 2'd3
  } flit_type_e;
endpackage

// File: rtl/msg_capture.sv
module msg_capture #(
  parameter int ROUTE_W = 6,
  parameter int MTYPE_W = 3,
  parameter int VC_W    = 2,
  parameter int ADDR_W  = 34,
  parameter int CMD_W   = 8,
  parameter int LINE_W  = 512,
  parameter int SEQ_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ROUTE_W-1:0] route_i,
  input  logic [MTYPE_W-1:0] mtype_i,
  input  logic [VC_W-1:0]    vc_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [LINE_W-1:0]  line_i,
  output logic [ROUTE_W-1:0] route_o,
  output logic [MTYPE_W-1:0] mtype_o,
  output logic [VC_W-1:0]    vc_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [SEQ_W-1:0]   seq_o
);
  logic [SEQ_W-1:0] seq_next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_o    <= '0;
      mtype_o    <= '0;
      vc_o       <= '0;
      addr_o     <= '0;
      cmd_o      <= '0;
      line_o     <= '0;
      seq_o      <= '0;
      seq_next_q <= '0;
    end else if (load_i) begin
      route_o    <= route_i;
      mtype_o    <= mtype_i;
      vc_o       <= vc_i;
      addr_o     <= addr_i;
      cmd_o      <= cmd_i;
      line_o     <= line_i;
      seq_o      <= seq_next_q;
      seq_next_q <= seq_next_q + 1'b1;
    end
  end
endmodule

// File: rtl/flit_sequencer.sv
module flit_sequencer
  import flit_pkg::*;
#(
  parameter int NUM_CHUNKS = 4,
  localparam int IDX_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             is_data_i,
  input  logic             fire_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output flit_type_e       ftype_o
);
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      last_q <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
      last_q <= is_data_i ? IDX_W'(NUM_CHUNKS - 1) : '0;
    end else if (fire_i) begin
      if (idx_o == last_q) busy_o <= 1'b0;
      else                 idx_o  <= idx_o + 1'b1;
    end
  end

  always_comb begin
    if (last_q == '0)        ftype_o = FT_SINGLE;
    else if (idx_o == '0)    ftype_o = FT_HEAD;
    else if (idx_o == last_q) ftype_o = FT_TAIL;
    else                     ftype_o = FT_BODY;
  end
endmodule

// File: rtl/flit_formatter.sv
module flit_formatter
  import flit_pkg::*;
#(
  parameter int ROUTE_W    = 6,
  parameter int MTYPE_W    = 3,
  parameter int VC_W       = 2,
  parameter int ADDR_W     = 34,
  parameter int CMD_W      = 8,
  parameter int SEQ_W      = 6,
  parameter int CHUNK_W    = 128,
  parameter int NUM_CHUNKS = 4,
  localparam int IDX_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int LINE_W = CHUNK_W * NUM_CHUNKS,
  localparam int HDR_W  = ROUTE_W + MTYPE_W + SEQ_W + ADDR_W,
  localparam int FLIT_W = 2 + VC_W + HDR_W + CHUNK_W
) (
  input  flit_type_e         ftype_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [ROUTE_W-1:0] route_i,
  input  logic [MTYPE_W-1:0] mtype_i,
  input  logic [VC_W-1:0]    vc_i,
  input  logic [SEQ_W-1:0]   seq_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [LINE_W-1:0]  line_i,
  output logic [FLIT_W-1:0]  flit_o
);
  logic [CHUNK_W-1:0] chunk [NUM_CHUNKS];

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    assign chunk[g] = line_i[g*CHUNK_W +: CHUNK_W];
  end

  logic [CHUNK_W-1:0] payload;
  logic [HDR_W-1:0]   hdr;
  logic               hdr_on;

  always_comb begin
    hdr_on  = (ftype_i == FT_HEAD) || (ftype_i == FT_SINGLE);
    payload = (ftype_i == FT_SINGLE) ? {{(CHUNK_W-CMD_W){1'b0}}, cmd_i} : chunk[idx_i];
    hdr     = hdr_on ? {route_i, mtype_i, seq_i, addr_i} : '0;
    flit_o  = {ftype_i, vc_i, hdr, payload};
  end
endmodule

// File: rtl/flit_packetizer.sv
module flit_packetizer
  import flit_pkg::*;
#(
  parameter int ROUTE_W    = 6,
  parameter int MTYPE_W    = 3,
  parameter int VC_W       = 2,
  parameter int ADDR_W     = 34,
  parameter int CMD_W      = 8,
  parameter int SEQ_W      = 6,
  parameter int CHUNK_W    = 128,
  parameter int NUM_CHUNKS = 4,
  localparam int IDX_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int LINE_W = CHUNK_W * NUM_CHUNKS,
  localparam int FLIT_W = 2 + VC_W + ROUTE_W + MTYPE_W + SEQ_W + ADDR_W + CHUNK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_valid_i,
  output logic               msg_ready_o,
  input  logic               msg_is_data_i,
  input  logic [ROUTE_W-1:0] msg_route_i,
  input  logic [MTYPE_W-1:0] msg_type_i,
  input  logic [VC_W-1:0]    msg_vc_i,
  input  logic [ADDR_W-1:0]  msg_addr_i,
  input  logic [CMD_W-1:0]   msg_cmd_i,
  input  logic [LINE_W-1:0]  msg_line_i,
  output logic               flit_valid_o,
  input  logic               flit_ready_i,
  output logic [FLIT_W-1:0]  flit_o
);
  logic               busy, load, fire;
  logic [IDX_W-1:0]   idx;
  flit_type_e         ftype;
  logic [ROUTE_W-1:0] route_q;
  logic [MTYPE_W-1:0] mtype_q;
  logic [VC_W-1:0]    vc_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CMD_W-1:0]   cmd_q;
  logic [LINE_W-1:0]  line_q;
  logic [SEQ_W-1:0]   seq_q;

  assign msg_ready_o  = !busy;
  assign load         = msg_valid_i && !busy;
  assign fire         = busy && flit_ready_i;
  assign flit_valid_o = busy;

  msg_capture #(
    .ROUTE_W(ROUTE_W), .MTYPE_W(MTYPE_W), .VC_W(VC_W), .ADDR_W(ADDR_W),
    .CMD_W(CMD_W), .LINE_W(LINE_W), .SEQ_W(SEQ_W)
  ) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .route_i(msg_route_i), .mtype_i(msg_type_i), .vc_i(msg_vc_i),
    .addr_i(msg_addr_i), .cmd_i(msg_cmd_i), .line_i(msg_line_i),
    .route_o(route_q), .mtype_o(mtype_q), .vc_o(vc_q), .addr_o(addr_q),
    .cmd_o(cmd_q), .line_o(line_q), .seq_o(seq_q)
  );

  flit_sequencer #(.NUM_CHUNKS(NUM_CHUNKS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .is_data_i(msg_is_data_i),
    .fire_i(fire), .busy_o(busy), .idx_o(idx), .ftype_o(ftype)
  );

  flit_formatter #(
    .ROUTE_W(ROUTE_W), .MTYPE_W(MTYPE_W), .VC_W(VC_W), .ADDR_W(ADDR_W),
    .CMD_W(CMD_W), .SEQ_W(SEQ_W), .CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)
  ) u_fmt (
    .ftype_i(ftype), .idx_i(idx), .route_i(route_q), .mtype_i(mtype_q),
    .vc_i(vc_q), .seq_i(seq_q), .addr_i(addr_q), .cmd_i(cmd_q),
    .line_i(line_q), .flit_o(flit_o)
  );
endmodule

// File: rtl/flit_packetizer_chk.sv
module flit_packetizer_chk #(
  parameter int FLIT_W = 181
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              msg_valid_i,
  input logic              msg_ready_o,
  input logic              flit_valid_o,
  input logic              flit_ready_i,
  input logic [FLIT_W-1:0] flit_o
);
  logic [1:0] ft;
  logic       fire;
  assign ft   = flit_o[FLIT_W-1 -: 2];
  assign fire = flit_valid_o && flit_ready_i;

  p_busy_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o |-> !msg_ready_o);

  p_end_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (ft == 2'd2 || ft == 2'd3) |=> !flit_valid_o && msg_ready_o);

  p_hold_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o && !flit_ready_i |=> flit_valid_o && $stable(flit_o));

  p_start_type_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_ready_o |=> flit_valid_o && (ft == 2'd0 || ft == 2'd3));

  p_head_body_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && ft == 2'd0 |=> flit_valid_o && ft == 2'd1);

  p_no_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (ft == 2'd0 || ft == 2'd1) |=> flit_valid_o);
endmodule

bind flit_packetizer flit_packetizer_chk #(.FLIT_W(FLIT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_valid_i(msg_valid_i),
  .msg_ready_o(msg_ready_o), .flit_valid_o(flit_valid_o),
  .flit_ready_i(flit_ready_i), .flit_o(flit_o)
);

// File: tb/sim_flit_packetizer.sv
`timescale 1ns/1ps
module sim_flit_packetizer;
  localparam int FW = 181;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           msg_valid_i = 1'b0;
  logic           msg_ready_o;
  logic           msg_is_data_i = 1'b0;
  logic [5:0]     msg_route_i = '0;
  logic [2:0]     msg_type_i = '0;
  logic [1:0]     msg_vc_i = '0;
  logic [33:0]    msg_addr_i = '0;
  logic [7:0]     msg_cmd_i = '0;
  logic [511:0]   msg_line_i = '0;
  logic           flit_valid_o;
  logic           flit_ready_i = 1'b0;
  logic [FW-1:0]  flit_o;

  int errors = 0;
  int checks = 0;
  int seq_m = 0;
  bit pend = 0;
  logic [FW-1:0] exp_q[$];

  always #4 clk_i = ~clk_i;

  flit_packetizer u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] t, input logic [1:0] vc, input logic [5:0] rt,
                                        input logic [2:0] ty, input logic [5:0] sq,
                                        input logic [33:0] ad, input logic [127:0] pl);
    return {t, vc, rt, ty, sq, ad, pl};
  endfunction

  task automatic push_msg();
    logic [5:0] sq;
    sq = 6'(seq_m % 64);
    if (msg_is_data_i) begin
      exp_q.push_back(mk(2'd0, msg_vc_i, msg_route_i, msg_type_i, sq, msg_addr_i, msg_line_i[127:0]));
      exp_q.push_back(mk(2'd1, msg_vc_i, '0, '0, '0, '0, msg_line_i[255:128]));
      exp_q.push_back(mk(2'd1, msg_vc_i, '0, '0, '0, '0, msg_line_i[383:256]));
      exp_q.push_back(mk(2'd2, msg_vc_i, '0, '0, '0, '0, msg_line_i[511:384]));
    end else begin
      exp_q.push_back(mk(2'd3, msg_vc_i, msg_route_i, msg_type_i, sq, msg_addr_i, {120'd0, msg_cmd_i}));
    end
    seq_m++;
  endtask

  task automatic new_msg(input int data_pct);
    msg_is_data_i = ($urandom_range(99) < data_pct);
    msg_route_i   = 6'($urandom);
    msg_type_i    = 3'($urandom);
    msg_vc_i      = 2'($urandom);
    msg_addr_i    = {2'($urandom), 32'($urandom)};
    msg_cmd_i     = 8'($urandom);
    for (int w = 0; w < 16; w++) msg_line_i[w*32 +: 32] = $urandom;
  endtask

  task automatic run(input int cycles, input int rdy_pct, input int msg_pct, input int data_pct);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      if (!pend && $urandom_range(99) < msg_pct) begin
        new_msg(data_pct);
        pend = 1;
      end
      msg_valid_i  = pend;
      flit_ready_i = ($urandom_range(99) < rdy_pct);
      #1;
      chk(msg_ready_o == (exp_q.size() == 0), "R6 msg_ready", FW'(msg_ready_o), FW'(exp_q.size() == 0));
      chk(flit_valid_o == (exp_q.size() != 0), "R10 flit_valid", FW'(flit_valid_o), FW'(exp_q.size() != 0));
      if (flit_valid_o && exp_q.size() != 0)
        chk(flit_o === exp_q[0], "R1 R2 R3 R4 R5 R7 R8 flit content", flit_o, exp_q[0]);
      if (flit_valid_o && flit_ready_i && exp_q.size() != 0) void'(exp_q.pop_front());
      if (msg_valid_i && msg_ready_o) begin
        push_msg();
        pend = 0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk(flit_valid_o == 1'b0, "R9 valid in reset", FW'(flit_valid_o), '0);
    chk(msg_ready_o == 1'b1, "R9 ready in reset", FW'(msg_ready_o), FW'(1));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(flit_valid_o == 1'b0, "R9 valid after reset", FW'(flit_valid_o), '0);
    chk(msg_ready_o == 1'b1, "R9 ready after reset", FW'(msg_ready_o), FW'(1));
    run(600,  100, 100, 100);  // R2 R10: back-to-back lines, link always ready
    run(600,  100, 100, 0);    // R5: commands only
    run(3000, 50,  90,  50);   // R7: mixed stalls
    run(3000, 15,  100, 70);   // R7: long stalls on every flit position
    run(2000, 80,  40,  50);   // R8: many packets, sequence wrap
    run(40,   100, 0,   50);   // drain
    chk(exp_q.size() == 0, "R6 drained", FW'(exp_q.size()), '0);
    chk(seq_m > 64, "R8 wrap exercised", FW'(seq_m), FW'(65));
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule